// File: doc/BRIEF.md
# Clock and reset control register block

A 32-bit register file for a clock and reset controller. Software reaches it over a plain word bus: an address, a write strobe, write data, and read data returned combinationally from the current address. The file holds control, configuration and fractional words for three PLLs, a read-only PLL status word, and a set of clock-divider control words. Every word has its own reset value and its own mask of bits that can be written.

Two parts of the map drive hardware outputs. A one-source interrupt is set by an event input. Its mask is changed only through a pair of write-only set and clear ports, and the mask register itself is read-only. A per-core reset word drives power-off pulses and power-on-with-reset pulses to four cores. Only the bits that change on a write produce a pulse. The block builds no PLL, clock divider or power sequencer. It only holds the words and derives these outputs.

Top module: `clkrst_regs`

## Requirements
- R1: Out of reset, aligned reads return these values. Interrupt status (0x00) reads 0 and interrupt mask (0x04) reads 1. PLL control words read 0x00012c09 (0x20), 0x00002c09 (0x30) and 0x00012809 (0x40). PLL config words (0x24, 0x34, 0x44) and fractional words (0x28, 0x38, 0x48) read 0. Core control (0x60) reads 0x03000400. Dividers read 0x01002500 (0x64), 0x01000500 (0x68), 0x00001500 (0x6c), 0x01001600 (0x70) and 0x01000800 (0x74). The core reset word (0x80) reads 0x00003d0f.
- R2: A write stores only the writable bits, and every other bit reads 0. The writable masks are 0x07737f09 for PLL control, 0xfe7fedef for PLL config, 0x81ccffff for fractional, 0x03003f07 for core control (0x60), 0x01003f07 for the dividers at 0x64 to 0x74, and 0x00003d0f for the core reset word.
- R3: The output irq is high exactly when status bit 0 is 1 and mask bit 0 is 0. It follows a register change in the cycle after the write or event.
- R4: irq_src high sets status bit 0 at the next edge. A write to 0x00 with data bit 0 set clears it, and an event in the same cycle wins over the clear. Writing 0 to that bit has no effect.
- R5: Bus writes to the mask register (0x04) have no effect. A write to 0x08 with data bit 0 set clears mask bit 0. A write to 0x0c with data bit 0 set sets mask bit 0. Reads of 0x08 and 0x0c return 0.
- R6: On a write to 0x80, each core bit i (bits 0 to 3) that goes from 0 to 1 raises cpu_off[i], and each that goes from 1 to 0 raises cpu_on_rst[i]. Each pulse lasts one cycle, starting in the cycle after the write. Bits that do not change, and all other cycles, give no pulse.
- R7: The PLL status word (0x50) always reads 0x0000003f, and writes to it have no effect.
- R8: An access with address bits 1:0 not zero, or to an address outside the map, reads 0 and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_src | input | 1 | Interrupt event, sets the status bit |
| irq | output | 1 | Unmasked interrupt |
| cpu_off | output | 4 | One-cycle power-off request per core |
| cpu_on_rst | output | 4 | One-cycle power-on-with-reset request per core |

## Verification
The bench builds the block with the default ADDR_W of 8, so one byte of address covers the whole map. It also covers the unmapped holes between groups and every misaligned offset inside each word. Each core-reset pattern is written from a known previous value: all cores on, alternate cores toggled, and a repeat of the same value. This shows that pulses follow changed bits only. Mask and status are driven through every path, including an event arriving in the same cycle as a clear.

// File: rtl/clkrst_regs.sv
module clkrst_regs #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              irq_src,
  output logic              irq,
  output logic [3:0]        cpu_off,
  output logic [3:0]        cpu_on_rst
);
  localparam int NSLOT   = 16;
  localparam int CPU_IDX = 15;
  localparam int OFF_STAT = 'h00;
  localparam int OFF_MASK = 'h04;
  localparam int OFF_SET  = 'h08;
  localparam int OFF_CLR  = 'h0c;
  localparam int OFF_PLLS = 'h50;
  localparam logic [31:0] PLLS_VAL = 32'h0000_003f;

  localparam int SLOT_OFF [NSLOT] = '{
    'h20, 'h24, 'h28, 'h30, 'h34, 'h38, 'h40, 'h44,
    'h48, 'h60, 'h64, 'h68, 'h6c, 'h70, 'h74, 'h80};
  localparam logic [31:0] SLOT_RST [NSLOT] = '{
    32'h0001_2c09, 32'h0, 32'h0, 32'h0000_2c09, 32'h0, 32'h0,
    32'h0001_2809, 32'h0, 32'h0, 32'h0300_0400, 32'h0100_2500,
    32'h0100_0500, 32'h0000_1500, 32'h0100_1600, 32'h0100_0800,
    32'h0000_3d0f};
  localparam logic [31:0] SLOT_WR [NSLOT] = '{
    32'h0773_7f09, 32'hfe7f_edef, 32'h81cc_ffff,
    32'h0773_7f09, 32'hfe7f_edef, 32'h81cc_ffff,
    32'h0773_7f09, 32'hfe7f_edef, 32'h81cc_ffff,
    32'h0300_3f07, 32'h0100_3f07, 32'h0100_3f07, 32'h0100_3f07,
    32'h0100_3f07, 32'h0100_3f07, 32'h0000_3d0f};

  logic [31:0] store [NSLOT];
  logic [NSLOT-1:0] hit;
  logic aligned;
  logic stat_q, mask_q;
  logic [3:0] core_old, core_new, core_chg;

  assign aligned = (bus_addr[1:0] == 2'b00);

  for (genvar i = 0; i < NSLOT; i++) begin : g_hit
    assign hit[i] = aligned && (bus_addr == ADDR_W'(SLOT_OFF[i]));
  end

  function automatic logic sel(input logic [ADDR_W-1:0] a, input int off);
    return (a[1:0] == 2'b00) && (a == ADDR_W'(off));
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOT; i++) store[i] <= SLOT_RST[i];
    end else if (bus_we) begin
      for (int i = 0; i < NSLOT; i++)
        if (hit[i]) store[i] <= bus_wdata & SLOT_WR[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= 1'b0;
      mask_q <= 1'b1;
    end else begin
      if (irq_src) stat_q <= 1'b1;
      else if (bus_we && sel(bus_addr, OFF_STAT) && bus_wdata[0]) stat_q <= 1'b0;
      if (bus_we && sel(bus_addr, OFF_CLR) && bus_wdata[0]) mask_q <= 1'b1;
      else if (bus_we && sel(bus_addr, OFF_SET) && bus_wdata[0]) mask_q <= 1'b0;
    end
  end

  assign irq = stat_q & ~mask_q;

  assign core_old = store[CPU_IDX][3:0];
  assign core_new = bus_wdata[3:0];
  assign core_chg = core_old ^ core_new;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_off    <= '0;
      cpu_on_rst <= '0;
    end else if (bus_we && hit[CPU_IDX]) begin
      cpu_off    <= core_chg & core_new;
      cpu_on_rst <= core_chg & ~core_new;
    end else begin
      cpu_off    <= '0;
      cpu_on_rst <= '0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NSLOT; i++)
      if (hit[i]) bus_rdata = store[i];
    if (sel(bus_addr, OFF_STAT)) bus_rdata = {31'b0, stat_q};
    if (sel(bus_addr, OFF_MASK)) bus_rdata = {31'b0, mask_q};
    if (sel(bus_addr, OFF_PLLS)) bus_rdata = PLLS_VAL;
  end
endmodule

// File: rtl/clkrst_regs_chk.sv
module clkrst_regs_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [31:0]       bus_rdata,
  input logic              irq_src,
  input logic              irq,
  input logic [3:0]        cpu_off,
  input logic [3:0]        cpu_on_rst
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'('h0c);
  localparam logic [ADDR_W-1:0] A_PLLS = ADDR_W'('h50);
  localparam logic [ADDR_W-1:0] A_CORE = ADDR_W'('h80);

  AST_PULSE_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_off & cpu_on_rst) == 4'b0); // R6
  AST_PULSE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ((cpu_off | cpu_on_rst) != 4'b0) |-> ($past(rst_n) && $past(bus_we) && $past(bus_addr) == A_CORE)); // R6
  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && bus_addr == A_STAT) |-> bus_rdata[0]); // R3
  AST_EVENT_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(irq_src) && bus_addr == A_STAT) |-> bus_rdata == 32'h1); // R4
  AST_MASK_PORTS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_SET || bus_addr == A_CLR) |-> bus_rdata == 32'h0); // R5
  AST_PLL_STATUS_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_PLLS) |-> bus_rdata == 32'h3f); // R7
  AST_MISALIGNED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[1:0] != 2'b00) |-> bus_rdata == 32'h0); // R8
endmodule

bind clkrst_regs clkrst_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_rdata(bus_rdata), .irq_src(irq_src), .irq(irq),
  .cpu_off(cpu_off), .cpu_on_rst(cpu_on_rst));

// File: tb/clkrst_regs_tb_top.sv
`timescale 1ns/1ps
module clkrst_regs_tb_top;
  logic clk = 0, rst_n = 0, bus_we = 0, irq_src = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic irq;
  logic [3:0] cpu_off, cpu_on_rst;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  clkrst_regs #(.ADDR_W(8)) dut_i (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_src(irq_src),
    .irq(irq), .cpu_off(cpu_off), .cpu_on_rst(cpu_on_rst));

  logic [31:0] m_rst[int], m_wr[int], m_val[int];
  logic m_st, m_mk, m_ready = 0;
  logic [3:0] e_off, e_on;

  initial begin
    m_rst['h20]=32'h00012c09; m_rst['h30]=32'h00002c09; m_rst['h40]=32'h00012809;
    foreach (m_rst[k]) m_wr[k]=32'h07737f09;
    for (int b = 'h20; b <= 'h40; b += 'h10) begin
      m_rst[b+4]=0; m_wr[b+4]=32'hfe7fedef; m_rst[b+8]=0; m_wr[b+8]=32'h81ccffff;
    end
    m_rst['h60]=32'h03000400; m_wr['h60]=32'h03003f07;
    m_rst['h64]=32'h01002500; m_rst['h68]=32'h01000500; m_rst['h6c]=32'h00001500;
    m_rst['h70]=32'h01001600; m_rst['h74]=32'h01000800;
    for (int b = 'h64; b <= 'h74; b += 4) m_wr[b]=32'h01003f07;
    m_rst['h80]=32'h00003d0f; m_wr['h80]=32'h00003d0f;
  end

  function automatic logic [31:0] exp_rd(logic [7:0] a);
    if (a[1:0] != 0) return 0;
    case (a)
      8'h00: return {31'b0, m_st};
      8'h04: return {31'b0, m_mk};
      8'h08, 8'h0c: return 0;
      8'h50: return 32'h3f;
      default: return m_val.exists(int'(a)) ? m_val[int'(a)] : 32'h0;
    endcase
  endfunction

  function automatic string tag_of(logic [7:0] a);
    if (a[1:0] != 0) return "R8";
    if (a == 8'h00) return "R4";
    if (a == 8'h04 || a == 8'h08 || a == 8'h0c) return "R5";
    if (a == 8'h50) return "R7";
    if (!m_val.exists(int'(a))) return "R8";
    return "R2";
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_rst[k]) m_val[k] = m_rst[k];
      m_st = 0; m_mk = 1; e_off = 0; e_on = 0; m_ready = 1;
    end else begin
      logic [3:0] nv, ch;
      e_off = 0; e_on = 0;
      if (irq_src) m_st = 1;
      else if (bus_we && bus_addr == 8'h00 && bus_wdata[0]) m_st = 0;
      if (bus_we && bus_addr[1:0] == 0) begin
        if (bus_addr == 8'h08 && bus_wdata[0]) m_mk = 0;
        if (bus_addr == 8'h0c && bus_wdata[0]) m_mk = 1;
        if (m_val.exists(int'(bus_addr))) begin
          if (bus_addr == 8'h80) begin
            nv = bus_wdata[3:0]; ch = nv ^ m_val['h80][3:0];
            e_off = ch & nv; e_on = ch & ~nv;
          end
          m_val[int'(bus_addr)] = bus_wdata & m_wr[int'(bus_addr)];
        end
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && m_ready && !done) begin
    chk("R3 irq", {31'b0, irq}, {31'b0, m_st & ~m_mk});
    chk("R6 cpu_off", {28'b0, cpu_off}, {28'b0, e_off});
    chk("R6 cpu_on_rst", {28'b0, cpu_on_rst}, {28'b0, e_on});
    chk({tag_of(bus_addr), " rdata"}, bus_rdata, exp_rd(bus_addr));
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(posedge clk); #1 bus_addr = a; bus_wdata = d; bus_we = 1;
    @(posedge clk); #1 bus_we = 0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    @(posedge clk); #1 bus_addr = a; bus_we = 0;
    @(negedge clk); chk(tag, bus_rdata, exp);
  endtask

  task automatic core(logic [31:0] d, logic [3:0] off, logic [3:0] on);
    wr(8'h80, d);
    @(negedge clk);
    chk("R6 off pulse", {28'b0, cpu_off}, {28'b0, off});
    chk("R6 on pulse", {28'b0, cpu_on_rst}, {28'b0, on});
    @(posedge clk); @(negedge clk);
    chk("R6 pulse ends", {24'b0, cpu_off, cpu_on_rst}, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk); #1 rst_n = 1;
    rd(8'h00, 0, "R1 status"); rd(8'h04, 1, "R1 mask");
    rd(8'h20, 32'h00012c09, "R1 pll a"); rd(8'h30, 32'h00002c09, "R1 pll d");
    rd(8'h40, 32'h00012809, "R1 pll v"); rd(8'h60, 32'h03000400, "R1 core ctl");
    rd(8'h74, 32'h01000800, "R1 div"); rd(8'h80, 32'h00003d0f, "R1 core rst");
    for (int a = 0; a < 'h88; a++) rd(8'(a), exp_rd(8'(a)), "R1 sweep");
    for (int a = 'h20; a < 'h80; a += 4) begin
      wr(8'(a), 32'hffffffff); rd(8'(a), exp_rd(8'(a)), "R2 ones");
      wr(8'(a), 32'h0); rd(8'(a), exp_rd(8'(a)), "R2 zeros");
    end
    wr(8'h20, 32'hffffffff); rd(8'h20, 32'h07737f09, "R2 pll mask");
    rd(8'h80, 32'h00003d0f, "R6 before");
    core(32'h0, 4'h0, 4'hf);
    core(32'h5, 4'h5, 4'h0);
    core(32'h5, 4'h0, 4'h0);
    core(32'hfffffffa, 4'ha, 4'h5);
    rd(8'h80, 32'h00003d0a, "R2 core mask");
    @(posedge clk); #1 irq_src = 1; @(posedge clk); #1 irq_src = 0;
    rd(8'h00, 1, "R4 set"); chk("R3 masked", {31'b0, irq}, 0);
    wr(8'h04, 0); rd(8'h04, 1, "R5 mask ro");
    wr(8'h08, 1); rd(8'h04, 0, "R5 enable"); chk("R3 irq high", {31'b0, irq}, 1);
    wr(8'h04, 1); rd(8'h04, 0, "R5 mask ro again");
    wr(8'h00, 0); rd(8'h00, 1, "R4 zero write");
    wr(8'h0c, 1); chk("R3 disabled", {31'b0, irq}, 0); rd(8'h04, 1, "R5 disable");
    wr(8'h08, 1); wr(8'h00, 1); rd(8'h00, 0, "R4 clear"); chk("R3 low", {31'b0, irq}, 0);
    @(posedge clk); #1 irq_src = 1; bus_addr = 0; bus_wdata = 1; bus_we = 1;
    @(posedge clk); #1 irq_src = 0; bus_we = 0;
    rd(8'h00, 1, "R4 set wins"); chk("R3 set wins", {31'b0, irq}, 1);
    wr(8'h50, 0); rd(8'h50, 32'h3f, "R7 pll status");
    wr(8'h21, 32'h0); rd(8'h20, 32'h07737f09, "R8 misaligned write");
    rd(8'h22, 0, "R8 misaligned read");
    wr(8'h10, 32'hffffffff); rd(8'h10, 0, "R8 unmapped");
    wr(8'h82, 32'h0); @(negedge clk);
    chk("R8 misaligned core", {24'b0, cpu_off, cpu_on_rst}, 0);
    rd(8'h80, 32'h00003d0a, "R8 core kept");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1; tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule